// File: doc/BRIEF.md
# Branch Target and Condition Unit

This unit resolves the control-flow effect of 16-bit branch instructions for a small processor core. For every instruction presented with a valid strobe it decides whether the program counter must be redirected. It also produces the new program counter and any return address for the link register, and it flags encodings that it cannot execute. It handles five forms:

- a short conditional branch with a condition code tested against the N/Z/C/V flags;
- an unconditional branch with a wider offset;
- a long branch-with-link split over a prefix halfword and a suffix halfword;
- a register-indirect branch;
- a register-indirect branch-with-link.

The unit does not fetch instructions and does not own the register file. For indirect forms it presents the register index taken from the instruction combinationally, and the register file returns the operand in the same cycle. The only state inside is the 11-bit field carried from a long-branch prefix to its suffix. All results appear on registered outputs one clock after the instruction is presented. The PC input is the instruction address plus 4.

Top module: `branch_resolve`

## Requirements
- R1: While reset is held and after its release with no instruction, the outputs pc_we_o, lr_we_o and trap_o are 0 and pc_o and lr_o are 0. The stored long-branch prefix is also 0 after reset.
- R2: An instruction with bits [15:12] = 1101 is a conditional branch. The condition is bits [11:8]. When the condition holds, pc_o = pc_i + (sign-extended bits [7:0]) * 2 with pc_we_o = 1.
- R3: The flags input is {N,Z,C,V} in bits 3..0. Condition codes 0..13 are, in order:
  - EQ (Z), NE (!Z), CS (C), CC (!C);
  - MI (N), PL (!N), VS (V), VC (!V);
  - HI (C and !Z), LS (!C or Z);
  - GE (N==V), LT (N!=V), GT (!Z and N==V), LE (Z or N!=V).
  A failed condition gives no strobe and no trap.
- R4: Condition codes 14 and 15 never redirect the PC and set trap_o.
- R5: An instruction with bits [15:11] = 11100 always branches to pc_i + (sign-extended bits [10:0]) * 2.
- R6: A long-branch prefix has bits [15:13] = 111 and bits [12:11] = 10. It stores bits [10:0] and drives no strobe and no trap. Only a prefix changes the stored value. A suffix uses the stored value as-is, including when no prefix preceded it.
- R7: A long-branch suffix has bits [15:13] = 111 and bits [12:11] = 11. It writes pc_o = pc_i + (sign-extended stored prefix << 12) + (bits [10:0] << 1). It also writes lr_o = (pc_i - 2) with bit 0 set when SET_LINK_STATE = 1, with both strobes high.
- R8: Bits [15:13] = 111 with bits [12:11] = 01 set trap_o and write neither PC nor link.
- R9: An instruction with bits [15:8] = 0x47 and bits [2:0] = 000 is an indirect branch. reg_sel_o always equals bits [6:3], combinationally. When bit 0 of reg_data_i is 1, pc_o = reg_data_i with bit 0 cleared and pc_we_o = 1.
- R10: An indirect target whose bit 0 is 0 sets trap_o and writes neither PC nor link.
- R11: An indirect form with bit 7 = 1 writes lr_o with the same return value as R7, but only when the branch is taken. With bit 7 = 0 the link is never written.
- R12: Outputs update on the clock edge at which instr_valid_i is 1. Without a valid instruction, and for non-branch encodings, the next cycle has pc_we_o, lr_we_o and trap_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | 1 | Instruction halfword is valid this cycle |
| instr_i | input | 16 | Instruction halfword |
| pc_i | input | ADDR_W | Instruction address plus 4 |
| flags_i | input | 4 | Condition flags {N,Z,C,V} |
| reg_data_i | input | ADDR_W | Operand of the register selected by reg_sel_o |
| reg_sel_o | output | 4 | Register index for indirect forms |
| pc_we_o | output | 1 | PC write strobe |
| pc_o | output | ADDR_W | New PC value |
| lr_we_o | output | 1 | Link register write strobe |
| lr_o | output | ADDR_W | Link register value |
| trap_o | output | 1 | Unsupported or illegal branch encoding |

## Verification
The bench sweeps all sixteen condition codes against all sixteen flag patterns, with forward and backward offsets.
- A design that swaps two codes or misreads a signed-compare condition would branch on the wrong flag pattern.
- A design that treats codes 14 and 15 as ordinary conditions would jump instead of trapping.

Long branches are tested in three ways: a suffix with no prefix after reset, a negative prefix separated from its suffix by an unrelated instruction, and a positive prefix. These catch a prefix that is lost, corrupted by other instructions, or shifted by the wrong amount.

Indirect forms are run with both values of the target state bit. This exposes a design that writes the link on a refused branch, or that forgets to clear bit 0 of the target.

// File: rtl/brn_pkg.sv
package brn_pkg;

   localparam int FLG_N = 3;
   localparam int FLG_Z = 2;
   localparam int FLG_C = 1;
   localparam int FLG_V = 0;

   localparam int SHORT_OFF_W = 8;
   localparam int WIDE_OFF_W  = 11;
   localparam int REG_IDX_W   = 4;

   typedef enum logic [2:0] {
      KIND_NONE,
      KIND_COND,
      KIND_UNCOND,
      KIND_LPRE,
      KIND_LSUF,
      KIND_LBAD,
      KIND_IND
   } brn_kind_e;

   typedef struct packed {
      brn_kind_e  kind;
      logic [3:0] cond;
      logic       link;
   } brn_dec_t;

endpackage

// File: rtl/brn_decode.sv
module brn_decode
   import brn_pkg::*;
(
   input  logic [15:0]          instr_i,
   output brn_dec_t             dec_o,
   output logic [REG_IDX_W-1:0] reg_sel_o
);

   always_comb begin
      dec_o.kind = KIND_NONE;
      dec_o.cond = instr_i[11:8];
      dec_o.link = instr_i[7];
      if (instr_i[15:12] == 4'b1101) begin
         dec_o.kind = KIND_COND;
      end else if (instr_i[15:11] == 5'b11100) begin
         dec_o.kind = KIND_UNCOND;
      end else if (instr_i[15:13] == 3'b111) begin
         unique case (instr_i[12:11])
            2'b10:   dec_o.kind = KIND_LPRE;
            2'b11:   dec_o.kind = KIND_LSUF;
            default: dec_o.kind = KIND_LBAD;
         endcase
      end else if (instr_i[15:8] == 8'h47 && instr_i[2:0] == 3'b000) begin
         dec_o.kind = KIND_IND;
      end
   end

   assign reg_sel_o = instr_i[6:3];

endmodule

// File: rtl/brn_cond_eval.sv
module brn_cond_eval
   import brn_pkg::*;
(
   input  logic [3:0] cond_i,
   input  logic [3:0] flags_i,
   output logic       take_o,
   output logic       undef_o
);

   logic n, z, c, v;
   assign n = flags_i[FLG_N];
   assign z = flags_i[FLG_Z];
   assign c = flags_i[FLG_C];
   assign v = flags_i[FLG_V];

   always_comb begin
      take_o  = 1'b0;
      undef_o = 1'b0;
      unique case (cond_i)
         4'd0:    take_o = z;
         4'd1:    take_o = !z;
         4'd2:    take_o = c;
         4'd3:    take_o = !c;
         4'd4:    take_o = n;
         4'd5:    take_o = !n;
         4'd6:    take_o = v;
         4'd7:    take_o = !v;
         4'd8:    take_o = c && !z;
         4'd9:    take_o = !c || z;
         4'd10:   take_o = (n == v);
         4'd11:   take_o = (n != v);
         4'd12:   take_o = !z && (n == v);
         4'd13:   take_o = z || (n != v);
         default: undef_o = 1'b1;
      endcase
   end

endmodule

// File: rtl/brn_prefix_store.sv
module brn_prefix_store
   import brn_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load_i,
   input  logic [WIDE_OFF_W-1:0] data_i,
   output logic [WIDE_OFF_W-1:0] q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= '0;
      else if (load_i) q_o <= data_i;
   end

   // R6: the carried field changes only when a prefix is loaded
   a_r6_prefix_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(q_o));

endmodule

// File: rtl/brn_target_calc.sv
module brn_target_calc
   import brn_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter bit SET_LINK_STATE = 1'b1
) (
   input  logic [ADDR_W-1:0]      pc_i,
   input  logic [ADDR_W-1:0]      reg_data_i,
   input  logic [10:0]            field_i,
   input  logic [WIDE_OFF_W-1:0]  prefix_i,
   output logic [ADDR_W-1:0]      short_tgt_o,
   output logic [ADDR_W-1:0]      wide_tgt_o,
   output logic [ADDR_W-1:0]      long_tgt_o,
   output logic [ADDR_W-1:0]      ind_tgt_o,
   output logic [ADDR_W-1:0]      link_o
);

   localparam int SHORT_PAD = ADDR_W - SHORT_OFF_W - 1;
   localparam int WIDE_PAD  = ADDR_W - WIDE_OFF_W - 1;
   localparam int HI_SHIFT  = WIDE_OFF_W + 1;
   localparam int HI_PAD    = ADDR_W - WIDE_OFF_W - HI_SHIFT;

   logic [ADDR_W-1:0] short_off, wide_off, hi_off, lo_off, ret_addr;

   assign short_off = {{SHORT_PAD{field_i[SHORT_OFF_W-1]}}, field_i[SHORT_OFF_W-1:0], 1'b0};
   assign wide_off  = {{WIDE_PAD{field_i[WIDE_OFF_W-1]}}, field_i, 1'b0};
   assign hi_off    = {{HI_PAD{prefix_i[WIDE_OFF_W-1]}}, prefix_i, {HI_SHIFT{1'b0}}};
   assign lo_off    = {{WIDE_PAD{1'b0}}, field_i, 1'b0};

   assign short_tgt_o = pc_i + short_off;
   assign wide_tgt_o  = pc_i + wide_off;
   assign long_tgt_o  = pc_i + hi_off + lo_off;
   assign ind_tgt_o   = {reg_data_i[ADDR_W-1:1], 1'b0};
   assign ret_addr    = pc_i - ADDR_W'(2);

   generate
      if (SET_LINK_STATE) begin : g_link_marked
         assign link_o = {ret_addr[ADDR_W-1:1], 1'b1};
      end else begin : g_link_plain
         assign link_o = ret_addr;
      end
   endgenerate

endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
   import brn_pkg::*;
#(
   parameter int ADDR_W         = 32,
   parameter bit SET_LINK_STATE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 instr_valid_i,
   input  logic [15:0]          instr_i,
   input  logic [ADDR_W-1:0]    pc_i,
   input  logic [3:0]           flags_i,
   input  logic [ADDR_W-1:0]    reg_data_i,
   output logic [REG_IDX_W-1:0] reg_sel_o,
   output logic                 pc_we_o,
   output logic [ADDR_W-1:0]    pc_o,
   output logic                 lr_we_o,
   output logic [ADDR_W-1:0]    lr_o,
   output logic                 trap_o
);

   localparam int MIN_ADDR_W = 2 * WIDE_OFF_W + 2;

   initial begin
      if (ADDR_W < MIN_ADDR_W)
         $error("branch_resolve: ADDR_W must be at least %0d", MIN_ADDR_W);
   end

   brn_dec_t               dec;
   logic                   cond_take, cond_undef;
   logic [WIDE_OFF_W-1:0]  prefix_q;
   logic [ADDR_W-1:0]      short_tgt, wide_tgt, long_tgt, ind_tgt, link_val;

   brn_decode u_decode (
      .instr_i   (instr_i),
      .dec_o     (dec),
      .reg_sel_o (reg_sel_o)
   );

   brn_cond_eval u_cond (
      .cond_i  (dec.cond),
      .flags_i (flags_i),
      .take_o  (cond_take),
      .undef_o (cond_undef)
   );

   brn_prefix_store u_prefix (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (instr_valid_i && dec.kind == KIND_LPRE),
      .data_i (instr_i[WIDE_OFF_W-1:0]),
      .q_o    (prefix_q)
   );

   brn_target_calc #(
      .ADDR_W         (ADDR_W),
      .SET_LINK_STATE (SET_LINK_STATE)
   ) u_target (
      .pc_i        (pc_i),
      .reg_data_i  (reg_data_i),
      .field_i     (instr_i[10:0]),
      .prefix_i    (prefix_q),
      .short_tgt_o (short_tgt),
      .wide_tgt_o  (wide_tgt),
      .long_tgt_o  (long_tgt),
      .ind_tgt_o   (ind_tgt),
      .link_o      (link_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_we_o <= 1'b0;
         lr_we_o <= 1'b0;
         trap_o  <= 1'b0;
         pc_o    <= '0;
         lr_o    <= '0;
      end else begin
         pc_we_o <= 1'b0;
         lr_we_o <= 1'b0;
         trap_o  <= 1'b0;
         if (instr_valid_i) begin
            unique case (dec.kind)
               KIND_COND: begin
                  if (cond_undef) begin
                     trap_o <= 1'b1;
                  end else if (cond_take) begin
                     pc_we_o <= 1'b1;
                     pc_o    <= short_tgt;
                  end
               end
               KIND_UNCOND: begin
                  pc_we_o <= 1'b1;
                  pc_o    <= wide_tgt;
               end
               KIND_LSUF: begin
                  pc_we_o <= 1'b1;
                  pc_o    <= long_tgt;
                  lr_we_o <= 1'b1;
                  lr_o    <= link_val;
               end
               KIND_LBAD: trap_o <= 1'b1;
               KIND_IND: begin
                  if (reg_data_i[0]) begin
                     pc_we_o <= 1'b1;
                     pc_o    <= ind_tgt;
                     if (dec.link) begin
                        lr_we_o <= 1'b1;
                        lr_o    <= link_val;
                     end
                  end else begin
                     trap_o <= 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R12: nothing is issued in a cycle that follows no valid instruction
   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid_i |=> !pc_we_o && !lr_we_o && !trap_o);

   // R4: the two reserved condition codes trap and never branch
   a_r4_reserved_cond_traps: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid_i && instr_i[15:12] == 4'b1101 && instr_i[11:9] == 3'b111
      |=> trap_o && !pc_we_o);

   // R10: an indirect target with its state bit clear is refused
   a_r10_ind_refused: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid_i && instr_i[15:8] == 8'h47 && instr_i[2:0] == 3'b000 && !reg_data_i[0]
      |=> trap_o && !pc_we_o && !lr_we_o);

   // R11: the link is written only together with a taken branch
   a_r11_link_with_taken: assert property (@(posedge clk) disable iff (!rst_n)
      lr_we_o |-> pc_we_o && !trap_o);

   // R8: the unsupported long-branch half traps
   a_r8_bad_half_traps: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid_i && instr_i[15:11] == 5'b11101 |=> trap_o && !pc_we_o);

endmodule

// File: tb/test_branch_resolve.sv
module test_branch_resolve;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid = 1'b0;
   logic [15:0] instr = 16'h0000;
   logic [31:0] pc = 32'h0;
   logic [3:0]  flags = 4'h0;
   logic [31:0] opnd = 32'h0;
   logic [3:0]  reg_sel;
   logic        pc_we, lr_we, trap;
   logic [31:0] pc_out, lr_out;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   branch_resolve #(.ADDR_W(32), .SET_LINK_STATE(1'b1)) i_branch_resolve (
      .clk(clk), .rst_n(rst_n), .instr_valid_i(valid), .instr_i(instr),
      .pc_i(pc), .flags_i(flags), .reg_data_i(opnd), .reg_sel_o(reg_sel),
      .pc_we_o(pc_we), .pc_o(pc_out), .lr_we_o(lr_we), .lr_o(lr_out), .trap_o(trap)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic issue(input logic [15:0] ins, input logic [31:0] p,
                        input logic [3:0] fl, input logic [31:0] op);
      @(negedge clk);
      instr = ins; pc = p; flags = fl; opnd = op; valid = 1'b1;
      @(negedge clk);
      valid = 1'b0;
   endtask

   function automatic bit cond_holds(input int code, input logic [3:0] f);
      bit n, z, c, v;
      n = f[3]; z = f[2]; c = f[1]; v = f[0];
      case (code)
         0: return z;            1: return !z;
         2: return c;            3: return !c;
         4: return n;            5: return !n;
         6: return v;            7: return !v;
         8: return c && !z;      9: return !c || z;
         10: return n == v;      11: return n != v;
         12: return !z && n == v;
         13: return z || n != v;
         default: return 0;
      endcase
   endfunction

   task automatic t_reset();
      chk("R1", "pc_we", 32'(pc_we), 0);
      chk("R1", "lr_we", 32'(lr_we), 0);
      chk("R1", "trap", 32'(trap), 0);
      chk("R1", "pc_o", pc_out, 0);
      chk("R1", "lr_o", lr_out, 0);
   endtask

   task automatic t_conditional();
      for (int code = 0; code < 16; code++) begin
         for (int f = 0; f < 16; f++) begin
            logic [7:0]  off;
            logic [31:0] tgt;
            bit          tk;
            off = (f % 2 == 0) ? 8'h10 : 8'hF0;
            tgt = (f % 2 == 0) ? 32'h0000_8020 : 32'h0000_7FE0;
            tk  = cond_holds(code, 4'(f));
            issue({4'hD, 4'(code), off}, 32'h0000_8000, 4'(f), 32'h0);
            if (code < 14) begin
               chk("R3", "cond pc_we", 32'(pc_we), 32'(tk));
               chk("R3", "cond trap", 32'(trap), 0);
               if (tk) chk("R2", "cond target", pc_out, tgt);
            end else begin
               chk("R4", "reserved pc_we", 32'(pc_we), 0);
               chk("R4", "reserved trap", 32'(trap), 1);
            end
            chk("R2", "cond lr_we", 32'(lr_we), 0);
         end
      end
   endtask

   task automatic t_unconditional();
      issue(16'hE3FF, 32'h0000_1000, 4'h0, 32'h0);
      chk("R5", "fwd pc_we", 32'(pc_we), 1);
      chk("R5", "fwd target", pc_out, 32'h0000_17FE);
      issue(16'hE7FF, 32'h0000_1000, 4'h0, 32'h0);
      chk("R5", "back target", pc_out, 32'h0000_0FFE);
      chk("R5", "back lr_we", 32'(lr_we), 0);
   endtask

   task automatic t_long();
      // R6: suffix with nothing stored since reset
      issue(16'hF810, 32'h0000_1000, 4'h0, 32'h0);
      chk("R6", "bare suffix target", pc_out, 32'h0000_1020);
      chk("R7", "bare suffix link", lr_out, 32'h0000_0FFF);
      chk("R7", "bare suffix lr_we", 32'(lr_we), 1);
      issue(16'hF7FF, 32'h0000_2000, 4'h0, 32'h0);
      chk("R6", "prefix pc_we", 32'(pc_we), 0);
      chk("R6", "prefix lr_we", 32'(lr_we), 0);
      chk("R6", "prefix trap", 32'(trap), 0);
      issue(16'h1C08, 32'h0000_2002, 4'h0, 32'h0);
      chk("R12", "non-branch pc_we", 32'(pc_we), 0);
      issue(16'hF805, 32'h0000_2002, 4'h0, 32'h0);
      chk("R7", "neg suffix pc_we", 32'(pc_we), 1);
      chk("R7", "neg suffix target", pc_out, 32'h0000_100C);
      chk("R7", "neg suffix link", lr_out, 32'h0000_2001);
      issue(16'hF001, 32'h0000_3000, 4'h0, 32'h0);
      issue(16'hF800, 32'h0000_3000, 4'h0, 32'h0);
      chk("R7", "pos suffix target", pc_out, 32'h0000_4000);
   endtask

   task automatic t_bad_half();
      issue(16'hE923, 32'h0000_5000, 4'h0, 32'h0);
      chk("R8", "bad half trap", 32'(trap), 1);
      chk("R8", "bad half pc_we", 32'(pc_we), 0);
      chk("R8", "bad half lr_we", 32'(lr_we), 0);
   endtask

   task automatic t_indirect();
      issue(16'h4728, 32'h0000_0600, 4'h0, 32'h0000_3001);
      chk("R9", "reg_sel", 32'(reg_sel), 5);
      chk("R9", "plain pc_we", 32'(pc_we), 1);
      chk("R9", "plain target", pc_out, 32'h0000_3000);
      chk("R11", "plain lr_we", 32'(lr_we), 0);
      issue(16'h47F0, 32'h0000_0500, 4'h0, 32'h0000_4001);
      chk("R9", "link reg_sel", 32'(reg_sel), 14);
      chk("R11", "link lr_we", 32'(lr_we), 1);
      chk("R11", "link value", lr_out, 32'h0000_04FF);
      chk("R9", "link target", pc_out, 32'h0000_4000);
      issue(16'h47F0, 32'h0000_0700, 4'h0, 32'h0000_5000);
      chk("R10", "refused trap", 32'(trap), 1);
      chk("R10", "refused pc_we", 32'(pc_we), 0);
      chk("R11", "refused lr_we", 32'(lr_we), 0);
   endtask

   task automatic t_idle();
      issue(16'hE010, 32'h0000_1000, 4'h0, 32'h0);
      chk("R12", "branch issued", 32'(pc_we), 1);
      @(negedge clk);
      chk("R12", "idle pc_we", 32'(pc_we), 0);
      chk("R12", "idle trap", 32'(trap), 0);
      issue(16'h2005, 32'h0000_1000, 4'hF, 32'h1);
      chk("R12", "other pc_we", 32'(pc_we), 0);
      chk("R12", "other lr_we", 32'(lr_we), 0);
      chk("R12", "other trap", 32'(trap), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_long();
      t_conditional();
      t_unconditional();
      t_bad_half();
      t_indirect();
      t_idle();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule